// File: doc/BRIEF.md
# Byte-Split Bidirectional Latched Transceiver

This block joins two 16-bit buses, A and B, through two storage banks that face opposite ways: one carries data from A towards B, the other from B towards A. Neither path inverts data. Each direction is steered by three active-low controls: an enable, a latch enable and an output enable. Every control is split per byte lane, so the two 8-bit halves can be run on their own. Tying the lane controls together gives uniform full-width behaviour.

While a direction's enable and latch enable are both low in a lane, that lane is transparent. Its bank follows the source bus on every clock, and the destination sees the live source data in the same cycle. When the latch enable or the enable goes high, the bank keeps the value it captured at the last clock edge on which both were low. The destination then sees that stored word. Each destination lane is driven only when its enable and output enable are both low.

Tri-state pins are modelled as a data port plus a per-lane drive flag. An undriven lane reads zero on the data port. If one lane is set to drive both buses at once, the block raises a contention flag for that lane. It does not resolve the conflict: both drives stay on. Reset is synchronous and active low. It clears both banks, and every drive flag stays low while reset is asserted.

Top module: `bus_xcvr`

## Requirements
- R1: With the A-to-B enable, latch enable and output enable of a lane all low, the B data of that lane equals the A input of that lane in the same cycle, bit for bit and not inverted.
- R2: While a lane's A-to-B path is not transparent and is driven, its B data holds the value the A bus carried at the last clock edge on which that lane's enable and latch enable were both low.
- R3: The B drive flag of lane k (bits 8k+7..8k) is high exactly when that lane's A-to-B enable and output enable are both low and reset is not asserted. When the flag is low, the lane's B data reads zero.
- R4: The B-to-A path follows R1 to R3 on its own, with B as the source and A as the destination.
- R5: Each byte lane is controlled only by its own control bits. A lane's storage and outputs are unaffected by the other lane's controls.
- R6: When a lane's enable is high, its bank does not capture, even if the latch enable is low.
- R7: The contention flag of a lane is high exactly when that lane drives both the A bus and the B bus.
- R8: Reset clears both storage banks and holds every drive flag low. After reset is released, a bank that has not captured anything presents zero.
- R9: A bank captures data while its output enable is high. The stored value appears once the output is enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| a_in | input | 16 | Data seen on bus A |
| b_in | input | 16 | Data seen on bus B |
| ab_en_n | input | 2 | A-to-B enable per lane, active low |
| ab_le_n | input | 2 | A-to-B latch enable per lane, active low |
| ab_oe_n | input | 2 | A-to-B output enable per lane, active low |
| ba_en_n | input | 2 | B-to-A enable per lane, active low |
| ba_le_n | input | 2 | B-to-A latch enable per lane, active low |
| ba_oe_n | input | 2 | B-to-A output enable per lane, active low |
| a_out | output | 16 | Data driven onto bus A, zero where undriven |
| a_drive | output | 2 | Per-lane drive flag for bus A |
| b_out | output | 16 | Data driven onto bus B, zero where undriven |
| b_drive | output | 2 | Per-lane drive flag for bus B |
| contention | output | 2 | Per-lane flag: lane drives both buses |

## Verification
The assertions check the following on every cycle and in every lane:
- transparent pass-through in both directions;
- zeroed data on undriven lanes;
- a stable output while a driven lane holds;
- the contention flag when both directions are enabled;
- drives off during reset.

Only the bench's scenarios can show which value was captured, because that depends on history. This covers:
- a bank that refuses to capture while its enable is high, with the result read out later;
- data captured behind a disabled output;
- lanes that hold different words while the other lane runs transparent;
- a bank that reads zero after a mid-run reset.

// File: rtl/bus_xcvr_pkg.sv
// Package: shared types for the byte-split bidirectional transceiver.
// Assumes all control signals are active low.
package bus_xcvr_pkg;

    // Control bundle of one direction in one byte lane.
    typedef struct packed {
        logic en_n;
        logic le_n;
        logic oe_n;
    } lane_ctl_t;

    // True when the lane's bank is open (transparent and capturing).
    function automatic logic lane_open(input lane_ctl_t c);
        return !c.en_n && !c.le_n;
    endfunction

    // True when the lane's destination is enabled, ignoring reset.
    function automatic logic lane_enabled(input lane_ctl_t c);
        return !c.en_n && !c.oe_n;
    endfunction

endpackage

// File: rtl/bus_xcvr_lane.sv
// Module: one byte lane of one direction.
// It holds the storage for the lane and selects live or stored data for
// the destination bus.
// Assumes: synchronous active-low reset; an undriven lane reads zero.
module bus_xcvr_lane
    import bus_xcvr_pkg::*;
#(
    parameter int LANE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [LANE_W-1:0] din,
    input  lane_ctl_t         ctl,
    output logic [LANE_W-1:0] dout,
    output logic              drive
);

    logic [LANE_W-1:0] held;
    logic              open_w;

    assign open_w = lane_open(ctl);

    // Storage: follows the source while open, otherwise keeps its value.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            held <= '0;
        end else if (open_w) begin
            held <= din;
        end
    end

    // Drive qualification: suppressed while reset is asserted.
    always_comb begin
        drive = rst_n && lane_enabled(ctl);
    end

    // Output select: live data when transparent, stored data otherwise.
    always_comb begin
        if (!drive) begin
            dout = '0;
        end else if (open_w) begin
            dout = din;
        end else begin
            dout = held;
        end
    end

endmodule

// File: rtl/bus_xcvr_path.sv
// Module: one transfer direction across all byte lanes.
// Assumes: the control vectors carry one bit per lane, with lane 0 at bit 0.
module bus_xcvr_path
    import bus_xcvr_pkg::*;
#(
    parameter int LANES  = 2,
    parameter int LANE_W = 8,
    localparam int W     = LANES * LANE_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [W-1:0]     src,
    input  logic [LANES-1:0] en_n,
    input  logic [LANES-1:0] le_n,
    input  logic [LANES-1:0] oe_n,
    output logic [W-1:0]     dst,
    output logic [LANES-1:0] drive
);

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        lane_ctl_t ctl;

        // Control bundling: collect this lane's three control bits.
        always_comb begin
            ctl.en_n = en_n[g];
            ctl.le_n = le_n[g];
            ctl.oe_n = oe_n[g];
        end

        bus_xcvr_lane #(.LANE_W(LANE_W)) u_lane (
            .clk  (clk),
            .rst_n(rst_n),
            .din  (src[g*LANE_W +: LANE_W]),
            .ctl  (ctl),
            .dout (dst[g*LANE_W +: LANE_W]),
            .drive(drive[g])
        );
    end

endmodule

// File: rtl/bus_xcvr_contend.sv
// Module: per-lane detection of both buses driven at once.
// It only reports the condition; both drives stay on.
// Assumes: the drive flags are already qualified by reset.
module bus_xcvr_contend #(
    parameter int LANES = 2
) (
    input  logic [LANES-1:0] a_drive,
    input  logic [LANES-1:0] b_drive,
    output logic [LANES-1:0] clash
);

    for (genvar g = 0; g < LANES; g++) begin : g_chk
        // Clash detection: flag when one lane drives both sides.
        always_comb begin
            clash[g] = a_drive[g] && b_drive[g];
        end
    end

endmodule

// File: rtl/bus_xcvr.sv
// Module: top of the byte-split bidirectional latched transceiver.
// It places two opposing storage paths between buses A and B and flags
// lanes that drive both buses at once.
// Assumes: tri-state pins are modelled as a data port plus a drive flag.
module bus_xcvr #(
    parameter int LANES  = 2,
    parameter int LANE_W = 8,
    localparam int W     = LANES * LANE_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [W-1:0]     a_in,
    input  logic [W-1:0]     b_in,
    input  logic [LANES-1:0] ab_en_n,
    input  logic [LANES-1:0] ab_le_n,
    input  logic [LANES-1:0] ab_oe_n,
    input  logic [LANES-1:0] ba_en_n,
    input  logic [LANES-1:0] ba_le_n,
    input  logic [LANES-1:0] ba_oe_n,
    output logic [W-1:0]     a_out,
    output logic [LANES-1:0] a_drive,
    output logic [W-1:0]     b_out,
    output logic [LANES-1:0] b_drive,
    output logic [LANES-1:0] contention
);

    // A-to-B direction.
    bus_xcvr_path #(.LANES(LANES), .LANE_W(LANE_W)) u_ab (
        .clk  (clk),
        .rst_n(rst_n),
        .src  (a_in),
        .en_n (ab_en_n),
        .le_n (ab_le_n),
        .oe_n (ab_oe_n),
        .dst  (b_out),
        .drive(b_drive)
    );

    // B-to-A direction.
    bus_xcvr_path #(.LANES(LANES), .LANE_W(LANE_W)) u_ba (
        .clk  (clk),
        .rst_n(rst_n),
        .src  (b_in),
        .en_n (ba_en_n),
        .le_n (ba_le_n),
        .oe_n (ba_oe_n),
        .dst  (a_out),
        .drive(a_drive)
    );

    bus_xcvr_contend #(.LANES(LANES)) u_contend (
        .a_drive(a_drive),
        .b_drive(b_drive),
        .clash  (contention)
    );

endmodule

// File: rtl/bus_xcvr_chk.sv
// Module: assertion checker for bus_xcvr, attached with bind.
// Assumes the same parameters as the top module.
module bus_xcvr_chk #(
    parameter int LANES  = 2,
    parameter int LANE_W = 8,
    localparam int W     = LANES * LANE_W
) (
    input logic             clk,
    input logic             rst_n,
    input logic [W-1:0]     a_in,
    input logic [W-1:0]     b_in,
    input logic [LANES-1:0] ab_en_n,
    input logic [LANES-1:0] ab_le_n,
    input logic [LANES-1:0] ab_oe_n,
    input logic [LANES-1:0] ba_en_n,
    input logic [LANES-1:0] ba_le_n,
    input logic [LANES-1:0] ba_oe_n,
    input logic [W-1:0]     a_out,
    input logic [LANES-1:0] a_drive,
    input logic [W-1:0]     b_out,
    input logic [LANES-1:0] b_drive,
    input logic [LANES-1:0] contention
);

    // R8
    reset_quiet_chk: assert property (@(posedge clk)
        !rst_n |-> (a_drive == '0 && b_drive == '0));

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        // R1
        ab_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (!ab_en_n[g] && !ab_le_n[g] && !ab_oe_n[g])
            |-> b_out[g*LANE_W +: LANE_W] == a_in[g*LANE_W +: LANE_W]);

        // R4
        ba_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (!ba_en_n[g] && !ba_le_n[g] && !ba_oe_n[g])
            |-> a_out[g*LANE_W +: LANE_W] == b_in[g*LANE_W +: LANE_W]);

        // R3
        b_idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !b_drive[g] |-> b_out[g*LANE_W +: LANE_W] == '0);

        // R4
        a_idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !a_drive[g] |-> a_out[g*LANE_W +: LANE_W] == '0);

        // R2
        ab_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (!(!ab_en_n[g] && !ab_le_n[g]) && $past(!(!ab_en_n[g] && !ab_le_n[g]))
             && b_drive[g] && $past(b_drive[g]))
            |-> $stable(b_out[g*LANE_W +: LANE_W]));

        // R4
        ba_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (!(!ba_en_n[g] && !ba_le_n[g]) && $past(!(!ba_en_n[g] && !ba_le_n[g]))
             && a_drive[g] && $past(a_drive[g]))
            |-> $stable(a_out[g*LANE_W +: LANE_W]));

        // R7
        clash_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (!ab_en_n[g] && !ab_oe_n[g] && !ba_en_n[g] && !ba_oe_n[g])
            |-> contention[g]);

        // R7
        clash_needs_both_chk: assert property (@(posedge clk) disable iff (!rst_n)
            contention[g] |-> (!ab_oe_n[g] && !ba_oe_n[g]));
    end

endmodule

bind bus_xcvr bus_xcvr_chk #(.LANES(LANES), .LANE_W(LANE_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .a_in      (a_in),
    .b_in      (b_in),
    .ab_en_n   (ab_en_n),
    .ab_le_n   (ab_le_n),
    .ab_oe_n   (ab_oe_n),
    .ba_en_n   (ba_en_n),
    .ba_le_n   (ba_le_n),
    .ba_oe_n   (ba_oe_n),
    .a_out     (a_out),
    .a_drive   (a_drive),
    .b_out     (b_out),
    .b_drive   (b_drive),
    .contention(contention)
);

// File: tb/bus_xcvr_test.sv
`timescale 1ns/1ps
// Bench: behavioural reference model compared on every falling edge,
// plus tagged checks at scenario points.
module bus_xcvr_test;

    localparam int L  = 2;
    localparam int LW = 8;
    localparam int W  = L * LW;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [W-1:0] a_in = '0, b_in = '0;
    logic [L-1:0] ab_en_n = '1, ab_le_n = '1, ab_oe_n = '1;
    logic [L-1:0] ba_en_n = '1, ba_le_n = '1, ba_oe_n = '1;
    logic [W-1:0] a_out, b_out;
    logic [L-1:0] a_drive, b_drive, contention;

    int checks = 0;
    int errors = 0;
    string tag = "R8";

    int m_ab [L];
    int m_ba [L];

    always #2.5 clk = ~clk;

    bus_xcvr #(.LANES(L), .LANE_W(LW)) uut (
        .clk(clk), .rst_n(rst_n), .a_in(a_in), .b_in(b_in),
        .ab_en_n(ab_en_n), .ab_le_n(ab_le_n), .ab_oe_n(ab_oe_n),
        .ba_en_n(ba_en_n), .ba_le_n(ba_le_n), .ba_oe_n(ba_oe_n),
        .a_out(a_out), .a_drive(a_drive), .b_out(b_out),
        .b_drive(b_drive), .contention(contention)
    );

    task automatic cmp(input string t, input logic [W-1:0] got, input logic [W-1:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h at %0t", t, got, exp, $time);
        end
    endtask

    // Reference model update at each rising edge.
    always @(posedge clk) begin
        for (int k = 0; k < L; k++) begin
            if (!rst_n) begin
                m_ab[k] = 0;
                m_ba[k] = 0;
            end else begin
                if (!ab_en_n[k] && !ab_le_n[k]) m_ab[k] = int'(a_in[k*LW +: LW]);
                if (!ba_en_n[k] && !ba_le_n[k]) m_ba[k] = int'(b_in[k*LW +: LW]);
            end
        end
    end

    // Per-cycle comparison against the model.
    always @(negedge clk) begin
        logic [W-1:0] eb, ea;
        logic [L-1:0] edb, eda;
        for (int k = 0; k < L; k++) begin
            edb[k] = rst_n && !ab_en_n[k] && !ab_oe_n[k];
            eda[k] = rst_n && !ba_en_n[k] && !ba_oe_n[k];
            eb[k*LW +: LW] = !edb[k] ? '0 :
                (!ab_le_n[k] ? a_in[k*LW +: LW] : LW'(m_ab[k]));
            ea[k*LW +: LW] = !eda[k] ? '0 :
                (!ba_le_n[k] ? b_in[k*LW +: LW] : LW'(m_ba[k]));
        end
        cmp({tag, " b_out"}, b_out, eb);
        cmp("R3 b_drive", W'(b_drive), W'(edb));
        cmp({"R4 a_out ", tag}, a_out, ea);
        cmp("R4 a_drive", W'(a_drive), W'(eda));
        cmp("R7 contention", W'(contention), W'(edb & eda));
    end

    task automatic step(input int n);
        repeat (n) begin
            @(posedge clk);
            #1;
        end
    endtask

    initial begin
        #(200000 * 5);
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        // R8: reset with busy inputs and outputs requested.
        tag = "R8";
        a_in = 16'hA5C3; b_in = 16'h3C5A;
        ab_en_n = '0; ab_le_n = '0; ab_oe_n = '0;
        step(3);
        cmp("R8 drives off in reset", W'(b_drive | a_drive), '0);
        rst_n = 1'b1;
        ab_en_n = '1; ab_le_n = '1; ab_oe_n = '1;
        step(1);

        // R1: full-width transparent A to B, several patterns.
        tag = "R1";
        ab_en_n = '0; ab_le_n = '0; ab_oe_n = '0;
        foreach (a_in[i]) begin end
        a_in = 16'h1234; step(1);
        a_in = 16'hFFFF; step(1);
        a_in = 16'h0000; step(1);
        a_in = 16'h8001; #1;
        cmp("R1 live pass", b_out, 16'h8001);
        step(1);

        // R2: close the bank, change the source, output holds.
        tag = "R2";
        ab_le_n = '1; a_in = 16'h7E7E; #1;
        cmp("R2 hold", b_out, 16'h8001);
        step(2);

        // R6: enable high with latch enable low must not capture.
        tag = "R6";
        ab_en_n = '1; ab_le_n = '0; a_in = 16'hDEAD;
        step(2);
        ab_en_n = '0; ab_le_n = '1; #1;
        cmp("R6 no capture while disabled", b_out, 16'h8001);
        step(1);

        // R9: capture behind a disabled output, then enable.
        tag = "R9";
        ab_oe_n = '1; ab_le_n = '0; a_in = 16'hBEEF;
        step(1);
        ab_le_n = '1; a_in = 16'h0F0F;
        step(1);
        ab_oe_n = '0; #1;
        cmp("R9 stored value shown", b_out, 16'hBEEF);
        step(1);

        // R4: B to A transparent then hold.
        tag = "R4";
        ab_oe_n = '1;
        ba_en_n = '0; ba_le_n = '0; ba_oe_n = '0;
        b_in = 16'h4321; step(1);
        b_in = 16'hC0DE; step(1);
        ba_le_n = '1; b_in = 16'h0000; #1;
        cmp("R4 B to A hold", a_out, 16'hC0DE);
        step(1);

        // R5: lane 0 transparent, lane 1 holds.
        tag = "R5";
        ba_oe_n = '1;
        ab_oe_n = '0; ab_en_n = '0;
        ab_le_n = 2'b01; a_in = 16'h5511;
        step(1);
        ab_le_n = 2'b10; a_in = 16'h9922; #1;
        cmp("R5 lanes independent", b_out, 16'h5522);
        step(2);

        // R7: lane 1 drives both buses.
        tag = "R7";
        ba_en_n = 2'b01; ba_oe_n = 2'b01; ab_oe_n = 2'b00;
        #1;
        cmp("R7 contention lane 1", W'(contention), W'(2'b10));
        step(2);

        // R8: reset mid-run then show cleared banks.
        tag = "R8";
        rst_n = 1'b0; step(2);
        rst_n = 1'b1;
        ab_le_n = '1; ab_en_n = '0; ab_oe_n = '0;
        ba_le_n = '1; ba_en_n = '0; ba_oe_n = '1;
        #1;
        cmp("R8 cleared bank", b_out, '0);
        step(3);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule